// File: doc/BRIEF.md
# Left-aligned PWM channel with selectable polarity

This block is one pulse-width modulation channel. It advances an internal count on single-cycle enable pulses taken from one of four prescaled tick sources, and drives one waveform output whose period is a programmable number of those ticks. A polarity input sets the meaning of the duty value. With polarity 1 the duty value counts the high ticks at the start of each period. With polarity 0 it counts the low ticks at the start, and the output is high for the rest of the period.

Period and duty values are presented as levels. The channel copies them into working copies only when it starts and at each period wrap, so a period in progress is never shortened or reshaped. An alignment mode bit is captured only while the channel is stopped. The captured value is presented on `align_center` for a later alignment stage. The waveform produced here is always the left-aligned one.

Top module: `pwm_left_chan`

## Requirements
- R1: While running with working period P > 0, the count steps 0, 1, … P−1 and then returns to 0 on successive selected ticks, so the output repeats every P ticks.
- R2: With polarity 1 and working duty D < P, the output is high while the count is below D and low for the remaining P−D ticks of the period.
- R3: With polarity 0 and working duty D < P, the output is low while the count is below D and high for the remaining P−D ticks.
- R4: If D ≥ P, or if P = 0, the output is constantly high for polarity 1 and constantly low for polarity 0 while running.
- R5: `src_sel` (value i, 0–3) picks bit i of `tick_src` as the count tick. Each count value lasts from one pulse of that bit to the next.
- R6: The working period and duty are loaded from `period_in`/`duty_in` at every edge while stopped and at each wrap while running. Changes made mid-period take effect only from the next wrap.
- R7: While stopped, the count is 0 and `pwm_out` equals the inverse of `polarity`. The edge that first samples `enable` high starts the period at count 0, and the count first advances on the following tick.
- R8: `align_center` takes the value of `center_mode` at each clock edge at which the channel was stopped before that edge. While running, it holds, and it also holds on the first edge after `enable` falls.
- R9: After reset the channel is stopped, `align_center` is 0, and `pwm_out` equals the inverse of `polarity`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_src | input | 4 | Four prescaled tick enables, each a one-cycle pulse |
| src_sel | input | 2 | Index of the tick source that drives the count |
| enable | input | 1 | Run the channel when high |
| polarity | input | 1 | 1: duty sets high time at period start; 0: duty sets low time |
| center_mode | input | 1 | Requested alignment mode, captured only while stopped |
| period_in | input | 8 | Period in ticks |
| duty_in | input | 8 | Duty compare value in ticks |
| pwm_out | output | 1 | Waveform output |
| align_center | output | 1 | Captured alignment mode |

## Verification
The output is a combinational function of registered state. It therefore reflects a count value right after the edge that produced it, and the bench samples on the falling edge. After the edge that first sees `enable` high, the sample at k falling edges later (k ≥ 0) belongs to count k mod P when tick source 0 pulses every cycle. For slower sources, the length of each high and low run is measured and must be a whole multiple of that source's pulse spacing. Buffered value changes are checked against the wrap that is four edges after the start. Mode capture is checked one and two edges after `enable` falls, because the first of those edges still sees the channel running.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef enum logic {
    ALIGN_LEFT   = 1'b0,
    ALIGN_CENTER = 1'b1
  } align_e;

  // level driven for a given "active" compare result
  function automatic logic pwm_level(input logic running, input logic pol,
                                     input logic active);
    if (!running) return ~pol;
    return pol ? active : ~active;
  endfunction
endpackage

// File: rtl/pwm_tick_mux.sv
module pwm_tick_mux #(
  parameter int N_SRC = 4
) (
  input  logic [N_SRC-1:0]         tick_src,
  input  logic [$clog2(N_SRC)-1:0] sel,
  output logic                     tick
);
  localparam int SW = $clog2(N_SRC);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam logic [SW-1:0] IDX = SW'(i);
    assign hit[i] = tick_src[i] & (sel == IDX);
  end

  assign tick = |hit;
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] per_s,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic at_last;
  assign at_last = (per_s == '0) || (cnt == per_s - W'(1));
  assign wrap    = run & tick & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (wrap)     cnt <= '0;
    else if (tick)     cnt <= cnt + W'(1);
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && per_s != '0) |-> cnt < per_s);
  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_chan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wrap,
  input  logic [W-1:0] per_in,
  input  logic [W-1:0] dty_in,
  input  logic         mode_in,
  output logic [W-1:0] per_s,
  output logic [W-1:0] dty_s,
  output align_e       mode_q
);
  logic load;
  assign load = ~run | wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_s <= '0;
      dty_s <= '0;
    end else if (load) begin
      per_s <= per_in;
      dty_s <= dty_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= ALIGN_LEFT;
    else if (!run) mode_q <= align_e'(mode_in);
  end

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(per_s) && $stable(dty_s)));
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(mode_q));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_chan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         run,
  input  logic         pol,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] per_s,
  input  logic [W-1:0] dty_s,
  output logic         wave
);
  logic active;
  always_comb begin
    active = (per_s == '0) || (cnt < dty_s);
    wave   = pwm_level(run, pol, active);
  end
endmodule

// File: rtl/pwm_left_chan.sv
module pwm_left_chan
  import pwm_chan_pkg::*;
#(
  parameter int W     = 8,
  parameter int N_SRC = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         tick_src,
  input  logic [$clog2(N_SRC)-1:0] src_sel,
  input  logic                     enable,
  input  logic                     polarity,
  input  logic                     center_mode,
  input  logic [W-1:0]             period_in,
  input  logic [W-1:0]             duty_in,
  output logic                     pwm_out,
  output logic                     align_center
);
  logic         run_q;
  logic         tick;
  logic         wrap;
  logic [W-1:0] cnt;
  logic [W-1:0] per_s;
  logic [W-1:0] dty_s;
  align_e       mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= enable;
  end

  pwm_tick_mux #(.N_SRC(N_SRC)) u_mux (
    .tick_src (tick_src),
    .sel      (src_sel),
    .tick     (tick)
  );

  pwm_period_ctr #(.W(W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .tick  (tick),
    .per_s (per_s),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  pwm_shadow #(.W(W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .wrap    (wrap),
    .per_in  (period_in),
    .dty_in  (duty_in),
    .mode_in (center_mode),
    .per_s   (per_s),
    .dty_s   (dty_s),
    .mode_q  (mode_q)
  );

  pwm_wave #(.W(W)) u_wave (
    .run   (run_q),
    .pol   (polarity),
    .cnt   (cnt),
    .per_s (per_s),
    .dty_s (dty_s),
    .wave  (pwm_out)
  );

  assign align_center = (mode_q == ALIGN_CENTER);

  // R7
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> pwm_out == !polarity);
  // R4
  full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && per_s != '0 && dty_s >= per_s) |-> pwm_out == polarity);
endmodule

// File: tb/pwm_left_chan_tb.sv
module pwm_left_chan_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tick_src = 4'b0;
  logic [1:0] src_sel = 2'd0;
  logic       enable = 1'b0;
  logic       polarity = 1'b0;
  logic       center_mode = 1'b0;
  logic [7:0] period_in = 8'd0;
  logic [7:0] duty_in = 8'd0;
  logic       pwm_out;
  logic       align_center;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int bcnt = 0;

  always #10 clk = ~clk;

  pwm_left_chan u_dut (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .src_sel(src_sel),
    .enable(enable), .polarity(polarity), .center_mode(center_mode),
    .period_in(period_in), .duty_in(duty_in),
    .pwm_out(pwm_out), .align_center(align_center)
  );

  // tick source i pulses once every i+1 cycles
  initial forever begin
    @(negedge clk);
    bcnt++;
    for (int i = 0; i < 4; i++) tick_src[i] = ((bcnt % (i + 1)) == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int hi, prev, lo_run, hi_run, guard;
    int seq[9];
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 out", pwm_out, 1);
    chk("R9 mode", align_center, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 out after release", pwm_out, 1);

    // R7 idle level for both polarities, count held
    for (int p = 0; p < 2; p++) begin
      polarity = p[0];
      period_in = 8'd3; duty_in = 8'd1;
      repeat (4) begin
        @(negedge clk);
        chk("R7 idle out", pwm_out, p == 0 ? 1 : 0);
      end
    end

    // R1 R2 R3 R4: sweep period, duty, polarity on source 0
    src_sel = 2'd0;
    for (int pol = 0; pol < 2; pol++)
      for (int per = 0; per < 7; per++)
        for (int dty = 0; dty < 8; dty++) begin
          int span;
          enable = 1'b0;
          polarity = pol[0]; period_in = 8'(per); duty_in = 8'(dty);
          repeat (2) @(negedge clk);
          enable = 1'b1;
          span = (per == 0) ? 1 : per;
          hi = 0;
          for (int k = 0; k < 2 * span; k++) begin
            int act_lvl, e;
            @(negedge clk);
            act_lvl = (per == 0) ? 1 : (((k % per) < dty) ? 1 : 0);
            e = pol ? act_lvl : 1 - act_lvl;
            if (per == 0 || dty >= per) chk("R4 full level", pwm_out, e);
            else if (pol == 1) chk("R2 pol1 sample", pwm_out, e);
            else chk("R3 pol0 sample", pwm_out, e);
            if (k < span) hi += pwm_out;
          end
          if (per != 0 && dty < per)
            chk("R1 high ticks per period", hi, pol ? dty : per - dty);
          enable = 1'b0;
          @(negedge clk);
          chk("R7 stop out", pwm_out, pol ? 0 : 1);
        end

    // R5 source select: run lengths scale with the pulse spacing
    polarity = 1'b0; period_in = 8'd4; duty_in = 8'd1;
    for (int s = 0; s < 4; s++) begin
      enable = 1'b0; src_sel = 2'(s);
      repeat (2) @(negedge clk);
      enable = 1'b1;
      prev = 0; guard = 0;
      @(negedge clk);
      prev = pwm_out;
      while (!(prev == 1 && pwm_out == 0) && guard < 200) begin
        prev = pwm_out; @(negedge clk); guard++;
      end
      lo_run = 0;
      while (pwm_out == 0 && lo_run < 100) begin lo_run++; @(negedge clk); end
      hi_run = 0;
      while (pwm_out == 1 && hi_run < 100) begin hi_run++; @(negedge clk); end
      chk("R5 low run", lo_run, 1 * (s + 1));
      chk("R5 high run", hi_run, 3 * (s + 1));
    end

    // R6 mid-period change waits for wrap
    enable = 1'b0; src_sel = 2'd0; polarity = 1'b0;
    period_in = 8'd4; duty_in = 8'd1;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk); chk("R6 start cnt0", pwm_out, 0);
    @(negedge clk); chk("R6 cnt1", pwm_out, 1);
    period_in = 8'd6; duty_in = 8'd3;
    seq = '{1, 1, 0, 0, 0, 1, 1, 1, 0};
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      chk("R6 buffered sample", pwm_out, seq[k]);
    end

    // R8 mode capture only while stopped
    enable = 1'b0; center_mode = 1'b0;
    repeat (2) @(negedge clk);
    center_mode = 1'b1;
    @(negedge clk); chk("R8 capture stopped", align_center, 1);
    center_mode = 1'b0; enable = 1'b1;
    @(negedge clk); chk("R8 capture at start", align_center, 0);
    center_mode = 1'b1;
    repeat (3) begin
      @(negedge clk); chk("R8 hold running", align_center, 0);
    end
    enable = 1'b0;
    @(negedge clk); chk("R8 first stop edge", align_center, 0);
    @(negedge clk); chk("R8 second stop edge", align_center, 1);

    finish_run();
  end
endmodule